// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Stack

This block sequences interrupt acknowledge and end-of-interrupt traffic for a single CPU interface, including nested preemption. An acknowledge strobe takes the highest-pending ID, offered by an external priority search. The block either accepts that ID and makes it the running interrupt, or answers with the spurious ID 1023. An end-of-interrupt strobe carries an ID in the low ten bits of its data word and retires that interrupt.

Each accepted acknowledge records the previously running ID in a per-source link entry. The link entries therefore form a chain of preempted interrupts, with the running interrupt at its head. Completing the head restores the preempted interrupt. Completing an interrupt deeper in the chain unlinks it in place, so completions may arrive out of order. That unlink is carried out by a walker that visits one link per cycle and raises `busy` while it runs.

The block also emits a pending-clear strobe for every accepted interrupt. It emits a pending-set strobe when a completed level-sensitive source is still asserted. Both strobes are consumed by the pending-state logic outside this block.

Top module: `irq_ack_chain`

## Requirements
- R1: After reset, `run_id` is 1023, `run_prio` is the idle value 2^PRIO_W (0x100 for 8-bit priorities), `busy`, `ack_valid`, `pend_clr` and `pend_set` are 0, and every link entry holds 1023.
- R2: An acknowledge is refused when `hp_id` is 1023, is not below NUM_SRC, or has a priority that is not strictly below `run_prio`. A refused acknowledge answers with `ack_id` = 1023 and changes neither `run_id` nor `run_prio`, and it raises no `pend_clr`.
- R3: An accepted acknowledge answers with `ack_id` = `hp_id`. In the same cycle the ID becomes `run_id`, and a one-cycle `pend_clr` carries the ID on `pend_clr_id`. The previous `run_id` is stored in the link entry of the new interrupt.
- R4: `pend_clr_all` equals the shared-model bit (`src_shared`) of the acknowledged source: 1 clears the pending bit for all CPUs, and 0 clears it for this CPU only.
- R5: `run_prio` is the priority of the running source, captured when that source becomes running. It is the idle value whenever `run_id` is 1023. A later change of `src_prio` does not alter it.
- R6: An end-of-interrupt that arrives while `run_id` is 1023 is ignored: no `pend_set`, no state change.
- R7: The end-of-interrupt ID is `eoi_data[9:0]`; bits 31:10 have no effect.
- R8: Exactly one cycle after an accepted end-of-interrupt for a source below NUM_SRC, `pend_set` pulses with `pend_set_id` = that ID if the source is level-sensitive (`src_edge` = 0), enabled, targeted at this CPU and its line is high; otherwise `pend_set` stays 0.
- R9: Completing the running ID sets `run_id` to that interrupt's link entry in the next cycle. `run_prio` then becomes the current priority of the restored source, or the idle value.
- R10: Completing an ID that is not running leaves `run_id` unchanged and removes that ID from the chain. Later completions then restore interrupts in chain order without it. An ID absent from the chain leaves the chain intact.
- R11: While `busy` is high, acknowledge and end-of-interrupt strobes are dropped (no `ack_valid`, no state change). The walk takes at most NUM_SRC cycles. When both strobes arrive together, only the acknowledge is taken.
- R12: `ack_valid` pulses for exactly one cycle, in the cycle after an acknowledge strobe is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_req | input | 1 | Acknowledge strobe |
| hp_id | input | 10 | Highest-pending ID from the priority search |
| ack_valid | output | 1 | Acknowledge answer valid |
| ack_id | output | 10 | Acknowledged ID or 1023 |
| eoi_req | input | 1 | End-of-interrupt strobe |
| eoi_data | input | 32 | End-of-interrupt data word, ID in bits 9:0 |
| src_prio | input | NUM_SRC*PRIO_W | Per-source priority, source k at bits k*PRIO_W upward |
| src_edge | input | NUM_SRC | 1 = edge-triggered, 0 = level-sensitive |
| src_en | input | NUM_SRC | Source enable |
| src_level | input | NUM_SRC | Current line level |
| src_tgt | input | NUM_SRC | Source is targeted at this CPU |
| src_shared | input | NUM_SRC | 1 = shared 1-of-N model, 0 = N-to-N |
| pend_clr | output | 1 | Pending-clear strobe |
| pend_clr_id | output | 10 | ID to clear |
| pend_clr_all | output | 1 | Clear for all CPUs |
| pend_set | output | 1 | Pending-set strobe for a still-asserted level source |
| pend_set_id | output | 10 | ID to set pending |
| run_id | output | 10 | Running interrupt ID, 1023 when idle |
| run_prio | output | PRIO_W+1 | Running priority, 2^PRIO_W when idle |
| busy | output | 1 | Chain walk in progress |

## Verification
The assertions assume that requesters honour `busy` only in so far as a dropped strobe is allowed to give no answer. They also assume `eoi_req` is low from reset until the first accepted request, so that the look-back on `pend_set` has a defined cause. Priorities are taken as stable while a source sits in the chain, except where the latching of `run_prio` is the point of the test. The stimulus keeps to these limits: it never changes a chained source's priority except for a brief probe that it restores before the next request. It raises both strobes together only where that case is meant. It waits for `busy` to fall before each further completion, apart from the one acknowledge deliberately placed inside a walk.

// File: rtl/ict_pkg.sv
package ict_pkg;
   localparam int unsigned ID_W = 10;
   localparam logic [ID_W-1:0] NO_IRQ = 10'h3FF;
   typedef logic [ID_W-1:0] irq_id_t;
   typedef enum logic [0:0] {WK_IDLE = 1'b0, WK_STEP = 1'b1} walk_st_e;
endpackage

// File: rtl/ict_link_table.sv
// Per-source "previously running" links, reset to the spurious ID.
module ict_link_table
   import ict_pkg::*;
#(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned NRD     = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  irq_id_t             wr_idx,
   input  irq_id_t             wr_data,
   input  logic [NRD*ID_W-1:0] rd_idx,
   output logic [NRD*ID_W-1:0] rd_data
);
   irq_id_t ent_q [NUM_SRC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NUM_SRC; k++) ent_q[k] <= NO_IRQ;
      end else begin
         for (int k = 0; k < NUM_SRC; k++)
            if (wr_en && wr_idx == ID_W'(k)) ent_q[k] <= wr_data;
      end
   end

   // Out-of-range indices read as the spurious ID.
   for (genvar p = 0; p < NRD; p++) begin : g_rd
      irq_id_t idx;
      irq_id_t val;
      assign idx = rd_idx[p*ID_W +: ID_W];
      always_comb begin
         val = NO_IRQ;
         for (int k = 0; k < NUM_SRC; k++)
            if (idx == ID_W'(k)) val = ent_q[k];
      end
      assign rd_data[p*ID_W +: ID_W] = val;
   end
endmodule

// File: rtl/ict_chain_walker.sv
// Walks the preemption chain one link per cycle and unlinks the target.
module ict_chain_walker
   import ict_pkg::*;
#(
   parameter int unsigned NUM_SRC = 64
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start,
   input  irq_id_t start_cur,
   input  irq_id_t start_tgt,
   input  irq_id_t cur_link,
   input  irq_id_t tgt_link,
   output logic    busy,
   output irq_id_t cursor,
   output irq_id_t target,
   output logic    wr_en,
   output irq_id_t wr_idx,
   output irq_id_t wr_data
);
   localparam int unsigned CNT_W = $clog2(NUM_SRC + 1);
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(NUM_SRC - 1);

   walk_st_e         st_q;
   irq_id_t          cur_q, tgt_q;
   logic [CNT_W-1:0] cnt_q;
   logic             at_end, hit, stop;

   assign at_end = (cur_link == NO_IRQ);
   assign hit    = !at_end && (cur_link == tgt_q);
   assign stop   = at_end || hit || (cnt_q == LAST_STEP);

   assign busy    = (st_q == WK_STEP);
   assign cursor  = cur_q;
   assign target  = tgt_q;
   assign wr_en   = busy && hit;
   assign wr_idx  = cur_q;
   assign wr_data = tgt_link;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= WK_IDLE;
         cur_q <= NO_IRQ;
         tgt_q <= NO_IRQ;
         cnt_q <= '0;
      end else if (st_q == WK_IDLE) begin
         if (start) begin
            st_q  <= WK_STEP;
            cur_q <= start_cur;
            tgt_q <= start_tgt;
            cnt_q <= '0;
         end
      end else begin
         if (stop) begin
            st_q <= WK_IDLE;
         end else begin
            cur_q <= cur_link;
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ict_reassert.sv
// Re-pends a completed level-sensitive source whose line is still high.
module ict_reassert
   import ict_pkg::*;
#(
   parameter int unsigned NUM_SRC = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               probe,
   input  irq_id_t            probe_id,
   input  logic [NUM_SRC-1:0] src_edge,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [NUM_SRC-1:0] src_level,
   input  logic [NUM_SRC-1:0] src_tgt,
   output logic               set_o,
   output irq_id_t            set_id_o
);
   logic [NUM_SRC-1:0] armed;
   logic               sel;

   assign armed = ~src_edge & src_en & src_level & src_tgt;

   always_comb begin
      sel = 1'b0;
      for (int k = 0; k < NUM_SRC; k++)
         if (probe_id == ID_W'(k)) sel = armed[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         set_o    <= 1'b0;
         set_id_o <= NO_IRQ;
      end else begin
         set_o <= probe && sel;
         if (probe && sel) set_id_o <= probe_id;
      end
   end
endmodule

// File: rtl/irq_ack_chain.sv
module irq_ack_chain
   import ict_pkg::*;
#(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned PRIO_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ack_req,
   input  logic [9:0]                hp_id,
   output logic                      ack_valid,
   output logic [9:0]                ack_id,
   input  logic                      eoi_req,
   input  logic [31:0]               eoi_data,
   input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
   input  logic [NUM_SRC-1:0]        src_edge,
   input  logic [NUM_SRC-1:0]        src_en,
   input  logic [NUM_SRC-1:0]        src_level,
   input  logic [NUM_SRC-1:0]        src_tgt,
   input  logic [NUM_SRC-1:0]        src_shared,
   output logic                      pend_clr,
   output logic [9:0]                pend_clr_id,
   output logic                      pend_clr_all,
   output logic                      pend_set,
   output logic [9:0]                pend_set_id,
   output logic [9:0]                run_id,
   output logic [PRIO_W:0]           run_prio,
   output logic                      busy
);
   localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};
   localparam int unsigned     NRD       = 3;

   // Elaboration-time parameter checks
   if (NUM_SRC < 2 || NUM_SRC > 1020) begin : g_bad_src
      $error("irq_ack_chain: NUM_SRC must lie in 2..1020");
   end
   if (PRIO_W < 1 || PRIO_W > 16) begin : g_bad_prio
      $error("irq_ack_chain: PRIO_W must lie in 1..16");
   end

   function automatic logic [PRIO_W-1:0] prio_of(
      input logic [NUM_SRC*PRIO_W-1:0] tbl, input irq_id_t id);
      prio_of = '0;
      for (int k = 0; k < NUM_SRC; k++)
         if (id == ID_W'(k)) prio_of = tbl[k*PRIO_W +: PRIO_W];
   endfunction

   function automatic logic bit_of(input logic [NUM_SRC-1:0] v, input irq_id_t id);
      bit_of = 1'b0;
      for (int k = 0; k < NUM_SRC; k++)
         if (id == ID_W'(k)) bit_of = v[k];
   endfunction

   irq_id_t         run_q, ack_id_q, clr_id_q;
   logic [PRIO_W:0] prio_q;
   logic            ack_vld_q, clr_q, clr_all_q;

   logic unused_hi;
   assign unused_hi = ^eoi_data[31:ID_W];

   // Request acceptance
   logic    take_ack, take_eoi, eoi_live, eoi_head, hp_ok;
   irq_id_t eoi_id;
   logic [PRIO_W-1:0] hp_prio;

   assign eoi_id   = eoi_data[ID_W-1:0];
   assign hp_prio  = prio_of(src_prio, hp_id);
   assign hp_ok    = (hp_id < ID_W'(NUM_SRC)) && ({1'b0, hp_prio} < prio_q);
   assign take_ack = ack_req && !busy;
   assign take_eoi = eoi_req && !busy && !ack_req;
   assign eoi_live = take_eoi && (run_q != NO_IRQ);
   assign eoi_head = eoi_live && (eoi_id == run_q);

   // Link table and walker
   logic [NRD*ID_W-1:0] rd_idx, rd_data;
   irq_id_t head_link, cur_link, tgt_link;
   irq_id_t wk_cursor, wk_target, wk_wr_idx, wk_wr_data;
   logic    wk_wr_en, tbl_wr_en;
   irq_id_t tbl_wr_idx, tbl_wr_data;

   assign rd_idx    = {wk_target, wk_cursor, run_q};
   assign head_link = rd_data[0*ID_W +: ID_W];
   assign cur_link  = rd_data[1*ID_W +: ID_W];
   assign tgt_link  = rd_data[2*ID_W +: ID_W];

   assign tbl_wr_en   = (take_ack && hp_ok) || wk_wr_en;
   assign tbl_wr_idx  = (take_ack && hp_ok) ? hp_id : wk_wr_idx;
   assign tbl_wr_data = (take_ack && hp_ok) ? run_q : wk_wr_data;

   ict_link_table #(.NUM_SRC(NUM_SRC), .NRD(NRD)) u_links (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_wr_en),
      .wr_idx  (tbl_wr_idx),
      .wr_data (tbl_wr_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   ict_chain_walker #(.NUM_SRC(NUM_SRC)) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (eoi_live && !eoi_head),
      .start_cur (run_q),
      .start_tgt (eoi_id),
      .cur_link  (cur_link),
      .tgt_link  (tgt_link),
      .busy      (busy),
      .cursor    (wk_cursor),
      .target    (wk_target),
      .wr_en     (wk_wr_en),
      .wr_idx    (wk_wr_idx),
      .wr_data   (wk_wr_data)
   );

   ict_reassert #(.NUM_SRC(NUM_SRC)) u_reassert (
      .clk       (clk),
      .rst_n     (rst_n),
      .probe     (eoi_live),
      .probe_id  (eoi_id),
      .src_edge  (src_edge),
      .src_en    (src_en),
      .src_level (src_level),
      .src_tgt   (src_tgt),
      .set_o     (pend_set),
      .set_id_o  (pend_set_id)
   );

   // Running state and acknowledge answer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q     <= NO_IRQ;
         prio_q    <= IDLE_PRIO;
         ack_vld_q <= 1'b0;
         ack_id_q  <= NO_IRQ;
         clr_q     <= 1'b0;
         clr_id_q  <= NO_IRQ;
         clr_all_q <= 1'b0;
      end else begin
         ack_vld_q <= take_ack;
         clr_q     <= take_ack && hp_ok;
         if (take_ack) begin
            ack_id_q <= hp_ok ? hp_id : NO_IRQ;
            if (hp_ok) begin
               run_q     <= hp_id;
               prio_q    <= {1'b0, hp_prio};
               clr_id_q  <= hp_id;
               clr_all_q <= bit_of(src_shared, hp_id);
            end
         end else if (eoi_head) begin
            run_q  <= head_link;
            prio_q <= (head_link == NO_IRQ) ? IDLE_PRIO
                                            : {1'b0, prio_of(src_prio, head_link)};
         end
      end
   end

   assign ack_valid    = ack_vld_q;
   assign ack_id       = ack_id_q;
   assign pend_clr     = clr_q;
   assign pend_clr_id  = clr_id_q;
   assign pend_clr_all = clr_all_q;
   assign run_id       = run_q;
   assign run_prio     = prio_q;
endmodule

// File: rtl/ict_checker.sv
module ict_checker #(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned PRIO_W  = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ack_req,
   input logic            eoi_req,
   input logic            ack_valid,
   input logic [9:0]      ack_id,
   input logic            pend_clr,
   input logic [9:0]      pend_clr_id,
   input logic            pend_set,
   input logic [9:0]      run_id,
   input logic [PRIO_W:0] run_prio,
   input logic            busy
);
   localparam logic [9:0]      NONE = 10'h3FF;
   localparam logic [PRIO_W:0] IDLE = {1'b1, {PRIO_W{1'b0}}};

   logic [31:0] busy_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_run <= '0;
      else if (busy) busy_run <= busy_run + 1;
      else busy_run <= '0;
   end

   // R3
   ack_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid && ack_id != NONE |-> run_id == ack_id);
   // R2
   ack_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid && ack_id == NONE |-> $stable(run_id) && $stable(run_prio) && !pend_clr);
   // R5
   idle_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_id == NONE |-> run_prio == IDLE);
   // R5
   live_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_id != NONE |-> run_prio < IDLE);
   // R3
   clr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_clr |-> ack_valid && pend_clr_id == ack_id);
   // R12
   ack_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req && !busy |=> ack_valid);
   // R11
   drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && ack_req |=> !ack_valid);
   // R8
   set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_set |-> $past(eoi_req));
   // R6
   idle_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_req && !ack_req && !busy && run_id == NONE |=> !pend_set && run_id == NONE);
   // R11
   walk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= NUM_SRC);
endmodule

bind irq_ack_chain ict_checker #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ack_req     (ack_req),
   .eoi_req     (eoi_req),
   .ack_valid   (ack_valid),
   .ack_id      (ack_id),
   .pend_clr    (pend_clr),
   .pend_clr_id (pend_clr_id),
   .pend_set    (pend_set),
   .run_id      (run_id),
   .run_prio    (run_prio),
   .busy        (busy)
);

// File: tb/sim_irq_ack_chain.sv
module sim_irq_ack_chain;
   localparam int N = 8;
   localparam int W = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic         rst_n, ack_req, eoi_req;
   logic [9:0]   hp_id;
   logic [31:0]  eoi_data;
   logic [N*W-1:0] src_prio;
   logic [7:0]   edg, en, lvl, tgt, shr;
   logic         ack_valid, pend_clr, pend_clr_all, pend_set, busy;
   logic [9:0]   ack_id, pend_clr_id, pend_set_id, run_id;
   logic [W:0]   run_prio;
   logic [7:0]   pr [N];

   always_comb for (int k = 0; k < N; k++) src_prio[k*W +: W] = pr[k];

   irq_ack_chain #(.NUM_SRC(N), .PRIO_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .hp_id(hp_id),
      .ack_valid(ack_valid), .ack_id(ack_id), .eoi_req(eoi_req),
      .eoi_data(eoi_data), .src_prio(src_prio), .src_edge(edg),
      .src_en(en), .src_level(lvl), .src_tgt(tgt), .src_shared(shr),
      .pend_clr(pend_clr), .pend_clr_id(pend_clr_id),
      .pend_clr_all(pend_clr_all), .pend_set(pend_set),
      .pend_set_id(pend_set_id), .run_id(run_id), .run_prio(run_prio),
      .busy(busy));

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   int stk [16];
   int dep = 0;
   int last_ps, last_psid, last_bcyc;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_run();
      return (dep > 0) ? stk[dep-1] : 1023;
   endfunction
   function automatic int exp_prio();
      return (dep > 0) ? int'(pr[stk[dep-1]]) : 256;
   endfunction
   function automatic void model_remove(input int id);
      int at = -1;
      for (int k = 0; k < dep; k++) if (stk[k] == id) at = k;
      if (at >= 0) begin
         for (int k = at; k < dep - 1; k++) stk[k] = stk[k+1];
         dep--;
      end
   endfunction

   task automatic do_ack(input int id);
      hp_id = 10'(id); ack_req = 1'b1;
      @(negedge clk);
      ack_req = 1'b0;
   endtask

   task automatic do_eoi(input logic [31:0] d);
      eoi_data = d; eoi_req = 1'b1;
      @(negedge clk);
      eoi_req = 1'b0;
      last_ps = int'(pend_set); last_psid = int'(pend_set_id);
      last_bcyc = 0;
      while (busy) begin
         @(negedge clk);
         last_bcyc++;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; ack_req = 1'b0; eoi_req = 1'b0; hp_id = 10'h3FF;
      eoi_data = '0; edg = 8'hFF; en = 8'hFF; lvl = '0; tgt = 8'hFF;
      shr = 8'b1010_1010;
      for (int k = 0; k < N; k++) pr[k] = 8'(k*16 + 3);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 run_id", int'(run_id), 1023);
      chk("R1 run_prio", int'(run_prio), 256);
      chk("R1 busy", int'(busy), 0);
      chk("R1 ack_valid", int'(ack_valid), 0);
      chk("R1 pend_set", int'(pend_set), 0);

      // R2 spurious and out-of-range IDs
      do_ack(1023);
      chk("R2 ack 1023 valid", int'(ack_valid), 1);
      chk("R2 ack 1023 id", int'(ack_id), 1023);
      do_ack(9);
      chk("R2 out-of-range id", int'(ack_id), 1023);
      chk("R2 out-of-range run", int'(run_id), 1023);

      // Per-source sweep: R3 R4 R5 R7 R9 R12
      for (int i = 0; i < N; i++) begin
         logic [7:0] keep;
         do_ack(i);
         chk("R12 ack_valid", int'(ack_valid), 1);
         chk("R3 ack_id", int'(ack_id), i);
         chk("R3 run_id", int'(run_id), i);
         chk("R5 run_prio", int'(run_prio), i*16 + 3);
         chk("R3 pend_clr", int'(pend_clr), 1);
         chk("R3 pend_clr_id", int'(pend_clr_id), i);
         chk("R4 pend_clr_all", int'(pend_clr_all), int'(shr[i]));
         keep = pr[i]; pr[i] = 8'hFF;
         @(negedge clk);
         chk("R12 single pulse", int'(ack_valid), 0);
         chk("R5 latched prio", int'(run_prio), i*16 + 3);
         pr[i] = keep;
         do_eoi({22'h3F0F0F, 10'(i)});
         chk("R7 R9 pop to idle", int'(run_id), 1023);
         chk("R9 idle prio", int'(run_prio), 256);
      end

      // R2 priority refusal sweep
      pr[0] = 8'h10; pr[1] = 8'h30; pr[2] = 8'h40; pr[3] = 8'h50;
      pr[4] = 8'h40; pr[5] = 8'h70; pr[6] = 8'h20; pr[7] = 8'h3F;
      do_ack(4);
      for (int j = 0; j < N; j++) begin
         bit ok;
         if (j == 4) continue;
         ok = pr[j] < 8'h40;
         do_ack(j);
         chk("R2 ack_id", int'(ack_id), ok ? j : 1023);
         chk("R2 run_id", int'(run_id), ok ? j : 4);
         chk("R2 pend_clr", int'(pend_clr), int'(ok));
         if (ok) begin
            do_eoi(32'(j));
            chk("R9 restore", int'(run_id), 4);
            chk("R9 restore prio", int'(run_prio), 8'h40);
         end
      end
      do_eoi(32'd4);
      chk("R9 back to idle", int'(run_id), 1023);

      // R8 level re-assert sweep over source 2
      for (int c = 0; c < 16; c++) begin
         bit e;
         edg[2] = c[0]; en[2] = c[1]; lvl[2] = c[2]; tgt[2] = c[3];
         e = !c[0] && c[1] && c[2] && c[3];
         do_ack(2);
         do_eoi(32'd2);
         chk("R8 pend_set", last_ps, int'(e));
         if (e) chk("R8 pend_set_id", last_psid, 2);
      end
      edg = 8'hFF; en = 8'hFF; lvl = '0; tgt = 8'hFF;

      // R6 completion while idle
      edg[1] = 1'b0; lvl[1] = 1'b1;
      do_eoi(32'd1);
      chk("R6 no pend_set", last_ps, 0);
      chk("R6 run stays idle", int'(run_id), 1023);
      edg = 8'hFF; lvl = '0;

      // Nesting: R9 R10 R11
      for (int i = 0; i < N; i++) pr[i] = 8'(8'h80 - 16*i);
      for (int i = 0; i < N; i++) begin
         do_ack(i);
         stk[dep] = i; dep++;
         chk("R3 nest run", int'(run_id), i);
      end
      // deep out-of-order completion with an acknowledge inside the walk
      eoi_data = 32'd0; eoi_req = 1'b1;
      @(negedge clk);
      eoi_req = 1'b0;
      chk("R10 busy raised", int'(busy), 1);
      hp_id = 10'd7; ack_req = 1'b1;
      @(negedge clk);
      ack_req = 1'b0;
      chk("R11 ack dropped", int'(ack_valid), 0);
      begin
         int cyc = 0;
         while (busy) begin @(negedge clk); cyc++; end
         chk("R11 walk bound", int'(cyc <= N), 1);
      end
      model_remove(0);
      chk("R10 run unchanged", int'(run_id), exp_run());
      begin
         int ord [8] = '{5, 7, 0, 2, 6, 1, 4, 3};
         for (int k = 0; k < 8; k++) begin
            do_eoi(32'(ord[k]));
            model_remove(ord[k]);
            chk("R10 run_id", int'(run_id), exp_run());
            chk("R9 run_prio", int'(run_prio), exp_prio());
            chk("R11 walk bound", int'(last_bcyc <= N), 1);
         end
      end
      chk("R10 chain empty", int'(run_id), 1023);

      // R11 simultaneous strobes: acknowledge wins
      hp_id = 10'd3; ack_req = 1'b1; eoi_data = 32'd3; eoi_req = 1'b1;
      @(negedge clk);
      ack_req = 1'b0; eoi_req = 1'b0;
      chk("R11 ack wins", int'(run_id), 3);
      do_eoi(32'd3);
      chk("R11 cleanup", int'(run_id), 1023);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule